// File: doc/BRIEF.md
# Low-Side Current Sample-Hold Sequencer

This block turns a stream of signed current samples for one buck phase into a held monitor code. The sensor gives a meaningful reading only while the low-side switch conducts. The block therefore accepts a sample only when it lies well inside a low-side conduction interval. The interval must have begun at least a guard time before the sample. It must also last at least a second guard time after the sample, so the sample is clear of the high-side pulse on both sides. Between accepted samples, and across every high-side pulse, the last accepted value is held.

The code is offset binary. Mid-scale stands for zero current, and that is the output from reset until the first switching cycle. A fault input replaces the code with the all-ones value, which sits above the clamped normal range. A downstream controller therefore reads it as out of range. A one-cycle strobe marks each load of a new held value.

Top module: `isense_hold_seq`

## Requirements
- R1: After reset `monCode` is 0x800 (zero current) and `monStrobe` is 0.
- R2: Until a high-side pulse has ended for the first time after reset (`hsOn` 1 then 0), no sample is accepted, whatever `lsOn` and `sampleValid` do.
- R3: A cycle counts as conducting only when `lsOn`=1 and `hsOn`=0. A sample taken in the first POST_GUARD (4) conducting cycles of an unbroken conducting run is discarded. A non-conducting cycle, including one where both gates are on, restarts the run.
- R4: A sample taken in cycle t is loaded at the clock edge that ends cycle t+PRE_GUARD (4), and only if conduction has not broken through that cycle. Samples taken in the last PRE_GUARD cycles before the high-side pulse are therefore never reported.
- R5: While `hsOn`=1 and there is no fault, `monCode` keeps the last loaded value and `monStrobe` stays 0.
- R6: A loaded sample s (12-bit two's complement on `sampleData`) gives the code 0x800+s, clamped to the range 0x000 to 0xFF0.
- R7: At the edge where `faultIn`=1, `monCode` becomes 0xFFF and `monStrobe` is 0. Samples are not loaded while the fault is present. Once the fault drops, the code returns to the held value.
- R8: `monStrobe` is 1 for exactly the cycle after each load. A sample with `sampleValid`=0 is never loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsOn | input | 1 | High-side switch conducting |
| lsOn | input | 1 | Low-side switch conducting |
| sampleValid | input | 1 | Current sample present this cycle |
| sampleData | input | 12 | Signed current sample, two's complement |
| faultIn | input | 1 | Over-current or shorted high-side fault |
| monCode | output | 12 | Offset-binary monitor code |
| monStrobe | output | 1 | One-cycle pulse on each load of a new value |

## Verification
A guard counter that ran short or long shows up at the ports straight away. A strobe appears one or more cycles earlier or later than the fixed position counted from the start of conduction. The code then carries a value from a sample that should have been skipped. A wrong delay tap or a bad started flag changes the very first load after a high-side pulse. A held value that leaks through a pulse or a fault shows in the code on the cycle after the pulse or the fault begins.

// File: rtl/isense_pkg.sv
package isense_pkg;

  // Control-to-datapath strobes, one per cycle
  typedef struct packed {
    logic loadHold;   // capture the delayed sample into the hold register
    logic showFault;  // drive the reserved fault code
  } ctrlStrobes_t;

endpackage

// File: rtl/isense_ctrl.sv
module isense_ctrl
  import isense_pkg::*;
#(
  parameter int PRE_GUARD  = 4,
  parameter int POST_GUARD = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hsOn,
  input  logic         lsOn,
  input  logic         sampleValid,
  input  logic         faultIn,
  output ctrlStrobes_t ctl
);

  localparam int RUN_LIMIT = PRE_GUARD + POST_GUARD + 1;
  localparam int RUN_W     = $clog2(RUN_LIMIT + 1);

  logic             hsPrev;
  logic             started;
  logic [RUN_W-1:0] runLen;
  logic [RUN_W-1:0] runNext;
  logic             condNow;
  logic             startNow;
  logic             validIn;
  logic             tapValid;
  logic             windowOk;

  assign condNow  = lsOn & ~hsOn;
  assign startNow = hsPrev & ~hsOn;
  assign validIn  = sampleValid & (started | startNow);

  always_comb begin
    if (!condNow)
      runNext = '0;
    else if (runLen == RUN_W'(RUN_LIMIT))
      runNext = runLen;
    else
      runNext = runLen + 1'b1;
  end

  assign windowOk = (runNext == RUN_W'(RUN_LIMIT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsPrev  <= 1'b0;
      started <= 1'b0;
      runLen  <= '0;
    end else begin
      hsPrev  <= hsOn;
      started <= started | startNow;
      runLen  <= runNext;
    end
  end

  generate
    if (PRE_GUARD == 0) begin : g_noDelay
      assign tapValid = validIn;
    end else begin : g_delay
      logic [PRE_GUARD-1:0] validPipe;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          validPipe <= '0;
        end else begin
          validPipe[0] <= validIn;
          for (int i = 1; i < PRE_GUARD; i++)
            validPipe[i] <= validPipe[i-1];
        end
      end
      assign tapValid = validPipe[PRE_GUARD-1];
    end
  endgenerate

  assign ctl.loadHold  = tapValid & windowOk & ~faultIn;
  assign ctl.showFault = faultIn;

endmodule

// File: rtl/isense_datapath.sv
module isense_datapath
  import isense_pkg::*;
#(
  parameter int SAMP_W       = 12,
  parameter int CODE_W       = 12,
  parameter int PRE_GUARD    = 4,
  parameter int CLAMP_MARGIN = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SAMP_W-1:0] sampleData,
  input  ctrlStrobes_t      ctl,
  output logic [CODE_W-1:0] monCode,
  output logic              monStrobe
);

  localparam logic [CODE_W-1:0] ZERO_CODE  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] FAULT_CODE = '1;
  localparam logic [CODE_W-1:0] CLAMP_MAX  = FAULT_CODE - CODE_W'(CLAMP_MARGIN);
  localparam int                EXT_W      = ((SAMP_W > CODE_W) ? SAMP_W : CODE_W) + 2;

  logic [SAMP_W-1:0] tapData;
  logic [EXT_W-1:0]  extSum;
  logic [CODE_W-1:0] clamped;
  logic [CODE_W-1:0] holdReg;

  generate
    if (PRE_GUARD == 0) begin : g_noDelay
      assign tapData = sampleData;
    end else begin : g_delay
      logic [SAMP_W-1:0] dataPipe [PRE_GUARD];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < PRE_GUARD; i++)
            dataPipe[i] <= '0;
        end else begin
          dataPipe[0] <= sampleData;
          for (int i = 1; i < PRE_GUARD; i++)
            dataPipe[i] <= dataPipe[i-1];
        end
      end
      assign tapData = dataPipe[PRE_GUARD-1];
    end
  endgenerate

  // Offset the signed sample onto the zero-current code, then clamp
  always_comb begin
    extSum = {{(EXT_W - SAMP_W){tapData[SAMP_W-1]}}, tapData} + EXT_W'(ZERO_CODE);
    if (extSum[EXT_W-1])
      clamped = '0;
    else if (extSum > EXT_W'(CLAMP_MAX))
      clamped = CLAMP_MAX;
    else
      clamped = extSum[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= ZERO_CODE;
      monCode   <= ZERO_CODE;
      monStrobe <= 1'b0;
    end else begin
      monStrobe <= ctl.loadHold;
      if (ctl.loadHold)
        holdReg <= clamped;
      if (ctl.showFault)
        monCode <= FAULT_CODE;
      else if (ctl.loadHold)
        monCode <= clamped;
      else
        monCode <= holdReg;
    end
  end

endmodule

// File: rtl/isense_hold_seq.sv
module isense_hold_seq
  import isense_pkg::*;
#(
  parameter int SAMP_W       = 12,
  parameter int CODE_W       = 12,
  parameter int PRE_GUARD    = 4,
  parameter int POST_GUARD   = 4,
  parameter int CLAMP_MARGIN = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsOn,
  input  logic              lsOn,
  input  logic              sampleValid,
  input  logic [SAMP_W-1:0] sampleData,
  input  logic              faultIn,
  output logic [CODE_W-1:0] monCode,
  output logic              monStrobe
);

  ctrlStrobes_t ctl;

  isense_ctrl #(
    .PRE_GUARD (PRE_GUARD),
    .POST_GUARD(POST_GUARD)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hsOn       (hsOn),
    .lsOn       (lsOn),
    .sampleValid(sampleValid),
    .faultIn    (faultIn),
    .ctl        (ctl)
  );

  isense_datapath #(
    .SAMP_W      (SAMP_W),
    .CODE_W      (CODE_W),
    .PRE_GUARD   (PRE_GUARD),
    .CLAMP_MARGIN(CLAMP_MARGIN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleData(sampleData),
    .ctl       (ctl),
    .monCode   (monCode),
    .monStrobe (monStrobe)
  );

endmodule

// File: rtl/isense_hold_chk.sv
module isense_hold_chk #(
  parameter int CODE_W       = 12,
  parameter int CLAMP_MARGIN = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              hsOn,
  input logic              lsOn,
  input logic              faultIn,
  input logic [CODE_W-1:0] monCode,
  input logic              monStrobe
);

  localparam logic [CODE_W-1:0] FAULT_CODE = '1;
  localparam logic [CODE_W-1:0] CLAMP_MAX  = FAULT_CODE - CODE_W'(CLAMP_MARGIN);

  assert_fault_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |=> (monCode == FAULT_CODE) && !monStrobe);

  assert_no_load_in_hs_R5: assert property (@(posedge clk) disable iff (!rstN)
    hsOn |=> !monStrobe);

  assert_no_load_off_ls_R3: assert property (@(posedge clk) disable iff (!rstN)
    !lsOn |=> !monStrobe);

  assert_load_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    monStrobe |-> (monCode <= CLAMP_MAX));

endmodule

bind isense_hold_seq isense_hold_chk #(
  .CODE_W      (CODE_W),
  .CLAMP_MARGIN(CLAMP_MARGIN)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hsOn     (hsOn),
  .lsOn     (lsOn),
  .faultIn  (faultIn),
  .monCode  (monCode),
  .monStrobe(monStrobe)
);

// File: tb/sim_isense_hold_seq.sv
`timescale 1ns/1ps
module sim_isense_hold_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hsOn = 1'b0;
  logic        lsOn = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic        faultIn = 1'b0;
  logic [11:0] monCode;
  logic        monStrobe;

  int checks = 0;
  int errors = 0;
  logic [11:0] expHold = 12'h800;

  always #2.5 clk = ~clk;

  isense_hold_seq u0 (
    .clk(clk), .rstN(rstN), .hsOn(hsOn), .lsOn(lsOn),
    .sampleValid(sampleValid), .sampleData(sampleData), .faultIn(faultIn),
    .monCode(monCode), .monStrobe(monStrobe)
  );

  function automatic logic [11:0] toCode(int s);
    int v = 2048 + s;
    if (v < 0) v = 0;
    if (v > 4080) v = 4080;
    return 12'(v);
  endfunction

  task automatic checkOut(string req, logic [11:0] expCode, logic expStb);
    checks++;
    if (monCode !== expCode || monStrobe !== expStb) begin
      errors++;
      $display("FAIL %s: code=%h strobe=%b expected code=%h strobe=%b at %0t",
               req, monCode, monStrobe, expCode, expStb, $time);
    end
  endtask

  // Drive one cycle's inputs, then sample just after the edge
  task automatic step(logic hs, logic ls, logic v, int d, logic f);
    @(negedge clk);
    hsOn = hs; lsOn = ls; sampleValid = v; sampleData = 12'(d); faultIn = f;
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) step(0, 0, 0, 0, 0);
    @(negedge clk) rstN = 1'b1;
    #1;
    checkOut("R1", 12'h800, 1'b0);
    expHold = 12'h800;
  endtask

  task automatic testPreStart();
    for (int j = 0; j < 20; j++) begin
      step(0, 1, 1, 100 + j, 0);
      checkOut("R2", 12'h800, 1'b0);
    end
  endtask

  task automatic hsPulse(int n);
    for (int j = 0; j < n; j++) begin
      step(1, 0, 1, 500 + j, 0);
      checkOut("R5", expHold, 1'b0);
    end
  endtask

  function automatic int sampleOf(int kind, int j);
    if (kind == 0) return j * 16 - 100;
    if (kind == 1) return (j % 2) ? 2047 : -2048;
    return -100 - j;
  endfunction

  // Conducting window right after a high-side pulse; deadAt < 0 means no break
  task automatic lsWindow(int len, int kind, int deadAt);
    logic vh[64];
    int   dh[64];
    for (int j = 0; j < len; j++) begin
      logic ls;
      int   seg;
      int   s;
      logic acc;
      ls    = (j != deadAt);
      vh[j] = (kind == 1) ? (j % 5 != 3) : 1'b1;
      dh[j] = sampleOf(kind, j);
      step(0, ls, vh[j], dh[j], 0);
      seg = (deadAt >= 0 && j > deadAt) ? deadAt + 1 : 0;
      s   = j - 4;
      acc = ls && (s >= seg + 4) && vh[s >= 0 ? s : 0];
      if (acc) begin
        expHold = toCode(dh[s]);
        checkOut((kind == 1) ? "R6" : "R4", expHold, 1'b1);
      end else begin
        checkOut((j < 8 || deadAt >= 0) ? "R3" : "R8", expHold, 1'b0);
      end
    end
  endtask

  task automatic testFault();
    lsWindow(12, 0, -1);
    for (int j = 0; j < 2; j++) begin
      step(0, 1, 1, 900, 1);
      checkOut("R7", 12'hFFF, 1'b0);
    end
    for (int j = 0; j < 3; j++) begin
      step(1, 0, 1, 901, 0);
      checkOut("R7", expHold, 1'b0);
    end
    step(1, 0, 0, 0, 1);
    checkOut("R7", 12'hFFF, 1'b0);
    step(1, 0, 0, 0, 0);
    checkOut("R7", expHold, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testPreStart();
    hsPulse(3);
    lsWindow(16, 0, -1);
    hsPulse(5);
    lsWindow(20, 1, -1);
    hsPulse(2);
    lsWindow(24, 2, 10);
    hsPulse(4);
    testFault();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule